// File: doc/BRIEF.md
# Wired Remote Key Decoder

This block listens to the asynchronous serial line of a wired remote control and turns each received character into a key event. The line carries 8N1 characters at 9600 baud, and each key is sent as a single byte. A receiver oversamples the line at sixteen times the bit rate. It checks that the start bit is real and checks the stop bit, then hands the byte to a decoder that recognises six keys.

Each accepted key produces a one-cycle strobe, a three-bit key index and a repeat flag. The repeat flag separates a held button, which the remote re-sends at short intervals, from a fresh press of the same button. A separate one-cycle flag reports a character whose stop bit was low.

Two parameters set the timing. `BAUD_DIV` is the number of clock cycles per sixteenth of a bit. `GAP_CYCLES` is the largest strobe-to-strobe spacing, in clock cycles, that still counts as a repeat. The defaults suit a 50 MHz clock and a 0.75 s threshold. That threshold sits between the sub-half-second re-send interval of a held button and the one-second-or-longer spacing of separate presses.

Top module: `remote_key_rx`

## Requirements
- R1: The line idles high. A character is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts 16*BAUD_DIV cycles and is decided at mid-bit by a majority of three samples spaced BAUD_DIV cycles apart.
- R2: A byte is a valid key byte when bits 7 and 6 are both 1 and exactly one of bits 5..0 is 1. A valid key byte raises key_vld_o for exactly one cycle, with key_o equal to the index of the set bit. The codes are 0xC1 -> 0 (play), 0xC2 -> 1 (stop), 0xC4 -> 2 (previous), 0xC8 -> 3 (next), 0xD0 -> 4 (volume up) and 0xE0 -> 5 (volume down).
- R3: A correctly framed byte that is not a valid key byte raises neither key_vld_o nor ferr_o. It also does not change the timing reference used by the repeat rule.
- R4: A low pulse that is no longer low at the middle of the start bit is treated as a glitch and discarded, and produces no output.
- R5: A character whose stop bit samples low is dropped and pulses ferr_o for one cycle. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: A key event carries rpt_o = 1 when it has the same key as the previous key event and the two strobes are at most GAP_CYCLES cycles apart.
- R7: A key event for the same key as the previous one, arriving more than GAP_CYCLES cycles after it, carries rpt_o = 0.
- R8: rpt_o = 0 for a key different from the previous key event, and for the first key event after reset.
- R9: While reset is asserted and right after it is released, key_vld_o, ferr_o and rpt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial line from the remote, idle high |
| key_vld_o | output | 1 | One-cycle strobe for a decoded key |
| key_o | output | 3 | Key index, valid with key_vld_o |
| rpt_o | output | 1 | Repeat flag, valid with key_vld_o |
| ferr_o | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench builds the block with BAUD_DIV = 4, so one bit lasts 64 cycles, and with GAP_CYCLES = 2000. At these values a whole character takes 640 cycles. This puts strobe spacings of about 1922 and 2072 cycles within a short run, which tests the repeat rule just inside and just outside the threshold. The short bit time also lets the bench place a 12-cycle glitch well before the mid-point of the start bit, and hold a low stop bit for its full length.

// File: rtl/remote_key_rx.sv
module remote_key_rx #(
  parameter int unsigned BAUD_DIV   = 326,
  parameter int unsigned GAP_CYCLES = 37_500_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       key_vld_o,
  output logic [2:0] key_o,
  output logic       rpt_o,
  output logic       ferr_o
);
  localparam int DW = $clog2(BAUD_DIV + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} st_t;

  st_t          st;
  logic [1:0]   sync;
  logic [DW-1:0] div_cnt;
  logic [3:0]   ph;
  logic [1:0]   smp;
  logic [2:0]   nbit;
  logic [7:0]   sh;
  logic [GW-1:0] gap;
  logic [2:0]   last_key;
  logic         seen;
  logic [2:0]   idx;

  wire rx_s = sync[1];
  wire tick = (div_cnt == DW'(BAUD_DIV - 1));
  wire mid  = tick && (ph == 4'd8);
  wire maj  = (smp[1] & smp[0]) | (smp[1] & rx_s) | (smp[0] & rx_s);
  wire hit  = (sh[7:6] == 2'b11) && $onehot(sh[5:0]);
  wire stop_mid = (st == S_STOP) && mid;
  wire ev   = stop_mid && maj && hit;

  always_comb begin
    idx = 3'd0;
    for (int i = 0; i < 6; i++)
      if (sh[i]) idx = 3'(i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync    <= 2'b11;
      div_cnt <= '0;
    end else begin
      sync    <= {sync[0], rx_i};
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st   <= S_IDLE;
      ph   <= '0;
      smp  <= 2'b11;
      nbit <= '0;
      sh   <= '0;
    end else begin
      if (tick) smp <= {smp[0], rx_s};
      case (st)
        S_IDLE: if (tick && !rx_s) begin
          st <= S_START;
          ph <= 4'd1;
        end
        S_HOLD: if (rx_s) st <= S_IDLE;
        default: if (tick) begin
          ph <= ph + 4'd1;
          if (ph == 4'd8) begin
            case (st)
              S_START: if (maj) st <= S_IDLE;
                       else begin st <= S_DATA; nbit <= '0; end
              S_DATA: begin
                sh   <= {maj, sh[7:1]};
                nbit <= nbit + 3'd1;
                if (nbit == 3'd7) st <= S_STOP;
              end
              default: st <= maj ? S_IDLE : S_HOLD;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      key_vld_o <= 1'b0;
      ferr_o    <= 1'b0;
      key_o     <= '0;
      rpt_o     <= 1'b0;
      last_key  <= '0;
      seen      <= 1'b0;
      gap       <= '0;
    end else begin
      key_vld_o <= ev;
      ferr_o    <= stop_mid && !maj;
      if (ev) begin
        key_o    <= idx;
        rpt_o    <= seen && (idx == last_key) && (gap < GW'(GAP_CYCLES));
        last_key <= idx;
        seen     <= 1'b1;
        gap      <= '0;
      end else if (gap != GW'(GAP_CYCLES)) begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/remote_key_rx_chk.sv
module remote_key_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       key_vld_o,
  input logic [2:0] key_o,
  input logic       rpt_o,
  input logic       ferr_o
);
  logic       seen;
  logic [2:0] last;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen <= 1'b0;
      last <= '0;
    end else if (key_vld_o) begin
      seen <= 1'b1;
      last <= key_o;
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_o |=> !key_vld_o);
  p_code_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_o |-> key_o <= 3'd5);
  p_ferr_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |=> !ferr_o);
  p_ferr_no_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |-> !key_vld_o);
  p_new_key_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_o && (!seen || key_o != last)) |-> !rpt_o);
endmodule

bind remote_key_rx remote_key_rx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .key_vld_o(key_vld_o),
  .key_o(key_o), .rpt_o(rpt_o), .ferr_o(ferr_o)
);

// File: tb/test_remote_key_rx.sv
module test_remote_key_rx;
  localparam int DIV = 4;
  localparam int GAP = 2000;
  localparam int BIT = DIV * 16;

  // {byte[31:24], idle[23:12], expect_event[11], key[10:8], repeat[7]}
  localparam logic [31:0] VEC [0:12] = '{
    32'hC1064800, 32'hC13E8880, 32'hC14E2880, 32'hC1578800,
    32'hC2064900, 32'hC4064A00, 32'hC8064B00, 32'hD0064C00,
    32'hE0064D00, 32'hE01F4D80, 32'hC3064000, 32'h41064000,
    32'hE0064D00
  };

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic key_vld, rpt, ferr;
  logic [2:0] key;
  int checks = 0, fails = 0, ev_cnt = 0, fe_cnt = 0;
  logic [2:0] ev_key;
  logic ev_rpt;
  bit done = 1'b0;

  always #5 clk = ~clk;

  remote_key_rx #(.BAUD_DIV(DIV), .GAP_CYCLES(GAP)) i_remote_key_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .key_vld_o(key_vld), .key_o(key), .rpt_o(rpt), .ferr_o(ferr));

  always @(negedge clk) begin
    if (rst_n && key_vld) begin
      ev_cnt++;
      ev_key = key;
      ev_rpt = rpt;
    end
    if (rst_n && ferr) fe_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    rx <= 1'b0; cyc(BIT);
    for (int i = 0; i < 8; i++) begin rx <= b[i]; cyc(BIT); end
    rx <= stop; cyc(BIT);
    rx <= 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cyc(5);
    @(negedge clk);
    chk(!key_vld && !ferr && !rpt, "R9 reset outputs", {key_vld, ferr, rpt}, 0);
    rst_n <= 1'b1;
    cyc(3);
    @(negedge clk);
    chk(!key_vld && !ferr && !rpt, "R9 after release", {key_vld, ferr, rpt}, 0);

    for (int v = 0; v < 13; v++) begin
      int ev0, fe0;
      ev0 = ev_cnt; fe0 = fe_cnt;
      cyc(int'(VEC[v][23:12]));
      send(VEC[v][31:24], 1'b1);
      cyc(32);
      @(negedge clk);
      if (VEC[v][11]) begin
        chk(ev_cnt == ev0 + 1, "R1/R2 one event", ev_cnt - ev0, 1);
        chk(ev_key == VEC[v][10:8], "R2 key code", ev_key, VEC[v][10:8]);
        chk(ev_rpt == VEC[v][7], VEC[v][7] ? "R6 repeat" : "R7/R8 new press",
            ev_rpt, VEC[v][7]);
      end else begin
        chk(ev_cnt == ev0 && fe_cnt == fe0, "R3 invalid byte ignored", ev_cnt - ev0, 0);
      end
    end

    begin : glitch_r4
      int ev0, fe0;
      ev0 = ev_cnt; fe0 = fe_cnt;
      cyc(200);
      rx <= 1'b0; cyc(12); rx <= 1'b1;
      cyc(800);
      @(negedge clk);
      chk(ev_cnt == ev0 && fe_cnt == fe0, "R4 glitch discarded", ev_cnt - ev0, 0);
    end

    begin : frame_r5
      int ev0, fe0;
      ev0 = ev_cnt; fe0 = fe_cnt;
      cyc(200);
      send(8'hC1, 1'b0);
      cyc(100);
      @(negedge clk);
      chk(fe_cnt == fe0 + 1, "R5 framing error pulse", fe_cnt - fe0, 1);
      chk(ev_cnt == ev0, "R5 byte dropped", ev_cnt - ev0, 0);
      cyc(200);
      send(8'hC2, 1'b1);
      cyc(32);
      @(negedge clk);
      chk(ev_cnt == ev0 + 1 && ev_key == 3'd1, "R5 recovery", ev_key, 1);
      chk(ev_rpt == 1'b0, "R8 new key after error", ev_rpt, 0);
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end
endmodule